// File: doc/BRIEF.md
# Per-Chip Local Checksum Detector

This block protects the nine per-chip lanes of one memory burst with a local error-detection code. Each of the nine x8 chips contributes a 64-bit lane: the low 57 bits hold data and the top 7 bits hold a 7-bit one's-complement checksum of that data. On a write the block fills each lane's checksum field. On a read it recomputes every lane's sum and raises an error bit for each lane whose data and stored checksum disagree. A fault is therefore pinned to one chip instead of being reported for the whole rank.

The ninth lane is short. Only its low 56 bits are data. Its bit 56 is a surplus bit that belongs to a different protection tier, so it is left out of that lane's checksum and is passed through untouched. Nine lanes of 57 bits give 513 bits, which is the 512-bit line plus this one surplus bit.

A small state machine records what the single pipeline stage holds. ST_IDLE means there is no result. ST_ENCODED means an encoded write word is ready. ST_CHECKED means a checked read word and its error vector are ready. From any state, the block moves to ST_ENCODED when a valid write arrives, to ST_CHECKED when a valid read arrives, and to ST_IDLE when no transfer arrives. Results appear one cycle after the input, so back-to-back transfers of either kind run at one per cycle.

Top module: `lcd_detector`

## Requirements
- R1: On a valid write (in_write=1), for each lane c at bus bits [64c+63:64c], out_word bits [64c+63:64c+57] hold the bitwise complement of the one's-complement (end-around-carry) sum of the lane's 7-bit data words. These words are bits [6:0], [13:7], ..., [55:49] and bit 56 zero-extended. For example, an all-zero lane gets checksum 7'h7F.
- R2: On a valid write, data bits [64c+56:64c] of every lane reach out_word unchanged, out_err is all zero and out_multi is 0.
- R3: In lane 8 (bus bits [575:512]), bit 56 (bus bit 568) is excluded from the lane's sum and is passed through. Changing it alters neither the generated checksum nor that lane's read error bit.
- R4: On a valid read (in_write=0), out_word equals in_word. out_err[c] is 1 exactly when the one's-complement sum of lane c's data words plus its stored checksum (bits [64c+63:64c+57]) is not 7'h7F.
- R5: A read of a correctly encoded word with one flipped bit in lane c, other than bus bit 568, sets out_err to the one-hot value with only bit c set.
- R6: out_multi is 1 exactly when two or more bits of out_err are 1.
- R7: out_valid is 1 in the cycle after a cycle with in_valid=1 and 0 otherwise. When out_valid is 0, out_word, out_err and out_multi are zero.
- R8: While rst_n is low, out_valid, out_err, out_multi and out_word are zero.
- R9: Reads and writes may alternate on consecutive cycles. Each result reflects only its own input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A burst word is presented this cycle |
| in_write | input | 1 | 1 = generate checksums, 0 = check checksums |
| in_word | input | 576 | Nine 64-bit chip lanes; lane c at bits [64c+63:64c] |
| out_valid | output | 1 | Result present, one cycle after input |
| out_word | output | 576 | Encoded word (write) or unchanged word (read) |
| out_err | output | 9 | Per-chip checksum mismatch flags |
| out_multi | output | 1 | More than one chip flagged |

## Verification
The properties assume that in_write is only meaningful when in_valid is high. They also assume that in_valid and in_write carry known values at every clock edge after reset is released. The stimulus drives every control input on the falling edge with a defined value, including during idle gaps, so both conditions hold. The properties compare each result with the previous cycle's inputs, so they rely on no transfer being lost across the single stage. The stimulus feeds the same bit-flip patterns through read and write cycles in arbitrary interleaving, which keeps within that one-in, one-out model.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

    // Contents of the single pipeline stage
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ENCODED = 2'd1,
        ST_CHECKED = 2'd2
    } lcd_state_e;

endpackage

// File: rtl/lcd_csum.sv
// One's-complement sum of a data field taken as CSUM_W-bit words.
// Bits at and above USE_W are treated as zero.
module lcd_csum #(
    parameter int DATA_W = 57,
    parameter int CSUM_W = 7,
    parameter int USE_W  = 57
) (
    input  logic [DATA_W-1:0] data,
    output logic [CSUM_W-1:0] sum
);
    localparam int NWORDS   = (DATA_W + CSUM_W - 1) / CSUM_W;
    localparam int PADDED_W = NWORDS * CSUM_W;
    localparam logic [DATA_W-1:0] USE_MASK = {DATA_W{1'b1}} >> (DATA_W - USE_W);

    function automatic logic [CSUM_W-1:0] oc_add(input logic [CSUM_W-1:0] a,
                                                 input logic [CSUM_W-1:0] b);
        logic [CSUM_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[CSUM_W-1:0] + CSUM_W'(s[CSUM_W]);
    endfunction

    logic [PADDED_W-1:0] padded;

    always_comb begin
        padded = PADDED_W'(data & USE_MASK);
        sum    = '0;
        for (int i = 0; i < NWORDS; i++) begin
            sum = oc_add(sum, padded[i*CSUM_W +: CSUM_W]);
        end
    end

endmodule

// File: rtl/lcd_lane.sv
// One chip lane: checksum generation and check.
module lcd_lane #(
    parameter int LANE_W = 64,
    parameter int CSUM_W = 7,
    parameter int USE_W  = 57
) (
    input  logic [LANE_W-1:0] lane_in,
    output logic [LANE_W-1:0] lane_enc,
    output logic              lane_bad
);
    localparam int DATA_W = LANE_W - CSUM_W;

    logic [CSUM_W-1:0] data_sum;
    logic [CSUM_W-1:0] stored;
    logic [CSUM_W:0]   raw;
    logic [CSUM_W-1:0] total;

    lcd_csum #(
        .DATA_W (DATA_W),
        .CSUM_W (CSUM_W),
        .USE_W  (USE_W)
    ) u_sum (
        .data (lane_in[DATA_W-1:0]),
        .sum  (data_sum)
    );

    always_comb begin
        stored   = lane_in[LANE_W-1 -: CSUM_W];
        lane_enc = {~data_sum, lane_in[DATA_W-1:0]};
        raw      = {1'b0, data_sum} + {1'b0, stored};
        total    = raw[CSUM_W-1:0] + CSUM_W'(raw[CSUM_W]);
        lane_bad = (total != {CSUM_W{1'b1}});
    end

endmodule

// File: rtl/lcd_detector.sv
module lcd_detector
    import lcd_pkg::*;
#(
    parameter int CHIPS     = 9,
    parameter int LANE_W    = 64,
    parameter int CSUM_W    = 7,
    parameter int SURPLUS_W = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_write,
    input  logic [CHIPS*LANE_W-1:0] in_word,
    output logic                    out_valid,
    output logic [CHIPS*LANE_W-1:0] out_word,
    output logic [CHIPS-1:0]        out_err,
    output logic                    out_multi
);
    localparam int BUS_W  = CHIPS * LANE_W;
    localparam int DATA_W = LANE_W - CSUM_W;

    logic [BUS_W-1:0] enc_word;
    logic [CHIPS-1:0] chip_bad;

    for (genvar c = 0; c < CHIPS; c++) begin : g_lane
        localparam int USE_W = (c == CHIPS - 1) ? DATA_W - SURPLUS_W : DATA_W;
        lcd_lane #(
            .LANE_W (LANE_W),
            .CSUM_W (CSUM_W),
            .USE_W  (USE_W)
        ) u_lane (
            .lane_in  (in_word[c*LANE_W +: LANE_W]),
            .lane_enc (enc_word[c*LANE_W +: LANE_W]),
            .lane_bad (chip_bad[c])
        );
    end

    lcd_state_e       state, state_nx;
    logic [BUS_W-1:0] word_q;
    logic [CHIPS-1:0] err_q;

    always_comb begin
        if (!in_valid)     state_nx = ST_IDLE;
        else if (in_write) state_nx = ST_ENCODED;
        else               state_nx = ST_CHECKED;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Stage data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            err_q  <= '0;
        end else begin
            word_q <= !in_valid ? '0 : (in_write ? enc_word : in_word);
            err_q  <= (in_valid && !in_write) ? chip_bad : '0;
        end
    end

    // Outputs
    always_comb begin
        out_valid = 1'b0;
        out_word  = '0;
        out_err   = '0;
        out_multi = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_ENCODED: begin
                out_valid = 1'b1;
                out_word  = word_q;
            end
            ST_CHECKED: begin
                out_valid = 1'b1;
                out_word  = word_q;
                out_err   = err_q;
                out_multi = (err_q & (err_q - 1'b1)) != '0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/lcd_checker.sv
module lcd_checker #(
    parameter int CHIPS  = 9,
    parameter int LANE_W = 64,
    parameter int CSUM_W = 7
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    in_write,
    input logic [CHIPS*LANE_W-1:0] in_word,
    input logic                    out_valid,
    input logic [CHIPS*LANE_W-1:0] out_word,
    input logic [CHIPS-1:0]        out_err,
    input logic                    out_multi
);
    localparam int DATA_W = LANE_W - CSUM_W;
    localparam logic [LANE_W-1:0] LANE_MASK = {{CSUM_W{1'b0}}, {DATA_W{1'b1}}};
    localparam logic [CHIPS*LANE_W-1:0] BUS_MASK = {CHIPS{LANE_MASK}};

    assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_quiet_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_err == '0 && !out_multi && out_word == '0));

    assert_write_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_write) |=> (out_err == '0 && !out_multi));

    assert_write_keeps_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_write) |=> ((out_word & BUS_MASK) == ($past(in_word) & BUS_MASK)));

    assert_read_passthru_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_write) |=> (out_word == $past(in_word)));

    assert_multi_needs_two_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_multi |-> !$onehot0(out_err));

endmodule

bind lcd_detector lcd_checker #(
    .CHIPS  (CHIPS),
    .LANE_W (LANE_W),
    .CSUM_W (CSUM_W)
) u_lcd_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_write  (in_write),
    .in_word   (in_word),
    .out_valid (out_valid),
    .out_word  (out_word),
    .out_err   (out_err),
    .out_multi (out_multi)
);

// File: tb/test_lcd_detector.sv
`timescale 1ns/1ps
module test_lcd_detector;
    localparam int BW = 576;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_write = 1'b0;
    logic [BW-1:0] in_word = '0;
    logic          out_valid;
    logic [BW-1:0] out_word;
    logic [8:0]    out_err;
    logic          out_multi;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic          exp_valid = 1'b0;
    logic          exp_wr = 1'b0;
    logic [BW-1:0] exp_word = '0;
    logic [8:0]    exp_err = '0;
    logic          exp_multi = 1'b0;
    string         exp_tag = "R7 idle";

    always #5 clk = ~clk;

    lcd_detector i_lcd_detector (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_write(in_write),
        .in_word(in_word), .out_valid(out_valid), .out_word(out_word),
        .out_err(out_err), .out_multi(out_multi)
    );

    function automatic int fold(input int s);
        int r = s;
        while (r > 127) r = (r & 127) + (r >> 7);
        return r;
    endfunction

    // Sum of a lane's data bits, weighted by position within a 7-bit word
    function automatic int lane_sum(input logic [BW-1:0] w, input int c);
        int s = 0;
        for (int k = 0; k < 57; k++) begin
            if (!(c == 8 && k == 56) && w[c*64+k]) s += (1 << (k % 7));
        end
        return fold(s);
    endfunction

    function automatic logic [BW-1:0] encode(input logic [BW-1:0] w);
        logic [BW-1:0] r = w;
        for (int c = 0; c < 9; c++) r[c*64+57 +: 7] = 7'(127 - lane_sum(w, c));
        return r;
    endfunction

    function automatic logic [8:0] bad_lanes(input logic [BW-1:0] w);
        logic [8:0] b = '0;
        for (int c = 0; c < 9; c++) begin
            int t = fold(lane_sum(w, c) + int'(w[c*64+57 +: 7]));
            b[c] = (t != 127);
        end
        return b;
    endfunction

    function automatic logic [BW-1:0] rand_word();
        logic [BW-1:0] r;
        for (int i = 0; i < 18; i++) r[i*32 +: 32] = $urandom;
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [BW-1:0] act,
                       input logic [BW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic compare();
        chk(out_valid == exp_valid, {exp_tag, " / R7 out_valid"}, BW'(out_valid), BW'(exp_valid));
        chk(out_word == exp_word, exp_wr ? {exp_tag, " / R1 word"} : {exp_tag, " / R4 word"},
            out_word, exp_word);
        chk(out_err == exp_err, exp_wr ? {exp_tag, " / R2 err"} : {exp_tag, " / R4 err"},
            BW'(out_err), BW'(exp_err));
        chk(out_multi == exp_multi, {exp_tag, " / R6 multi"}, BW'(out_multi), BW'(exp_multi));
    endtask

    task automatic step(input bit v, input bit wr, input logic [BW-1:0] w, input string tag);
        @(negedge clk);
        compare();
        in_valid = v;
        in_write = wr;
        in_word  = w;
        exp_valid = v;
        exp_wr    = v && wr;
        exp_tag   = tag;
        if (!v) begin
            exp_word = '0; exp_err = '0;
        end else if (wr) begin
            exp_word = encode(w); exp_err = '0;
        end else begin
            exp_word = w; exp_err = bad_lanes(w);
        end
        exp_multi = ($countones(exp_err) > 1);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R7 watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [BW-1:0] w, e, f;
        in_word = rand_word();
        in_valid = 1'b1;
        in_write = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(out_valid == 1'b0 && out_err == '0 && !out_multi && out_word == '0,
                "R8 reset outputs", {out_valid, out_multi, out_err}, '0);
        end
        in_valid = 1'b0;
        in_word  = '0;
        @(negedge clk);
        rst_n = 1'b1;

        // All-zero write: every checksum field 7'h7F
        step(1, 1, '0, "R1 zero encode");
        @(negedge clk);
        chk(out_word[575:569] == 7'h7F && out_word[63:57] == 7'h7F, "R1 zero checksum",
            BW'(out_word[63:57]), BW'(7'h7F));
        compare();
        in_valid = 1'b0;
        exp_valid = 0; exp_word = '0; exp_err = '0; exp_multi = 0; exp_tag = "R7 idle";

        step(1, 1, {BW{1'b1}}, "R1 ones encode");
        step(1, 0, encode({BW{1'b1}}), "R4 ones clean read");

        // Surplus bit does not enter lane 8's checksum
        w = rand_word();
        w[568] = 1'b0;
        f = w;
        f[568] = 1'b1;
        step(1, 1, w, "R3 surplus clear encode");
        step(1, 1, f, "R3 surplus set encode");
        step(1, 0, encode(w) ^ (BW'(1) << 568), "R3 surplus flip read");
        step(0, 0, '0, "R7 idle gap");
        @(negedge clk);
        chk(out_err[8] == 1'b0, "R3 surplus no error", BW'(out_err), '0);
        compare();
        in_valid = 1'b0;
        exp_valid = 0; exp_word = '0; exp_err = '0; exp_multi = 0; exp_tag = "R7 idle";

        for (int n = 0; n < 40; n++) begin
            int c  = n % 9;
            int b  = $urandom_range(63, 0);
            int c2 = (c + 1 + $urandom_range(7, 0)) % 9;
            if (c == 8 && b == 56) b = 55;
            w = rand_word();
            e = encode(w);
            step(1, 1, w, "R1 random encode");
            step(1, 0, e, "R9 clean read after write");
            f = e ^ (BW'(1) << (c*64 + b));
            step(1, 0, f, "R5 single flip");
            @(negedge clk);
            chk(out_err == 9'(1 << c), "R5 one-hot lane", BW'(out_err), BW'(9'(1 << c)));
            compare();
            in_valid = 1'b0;
            exp_valid = 0; exp_word = '0; exp_err = '0; exp_multi = 0; exp_tag = "R7 idle";
            f = f ^ (BW'(1) << (c2*64 + 3));
            step(1, 0, f, "R6 two-lane flip");
            if (n % 3 == 0) step(0, 1, rand_word(), "R7 idle with write set");
        end
        step(0, 0, '0, "R7 flush");
        step(0, 0, '0, "R7 flush");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule